// File: doc/BRIEF.md
# Counter-Based LRU Replacement Tracker

This block keeps least-recently-used ordering for every set of an N-way set-associative cache. Each way of each set carries a rank counter of log2(ASSOC) bits. Rank 0 is the most recently used way and rank ASSOC-1 the least recently used. The block holds no tags or data, and it does not decide whether an access hits. The surrounding cache presents a set index, a valid strobe, a hit flag and, on a hit, the way that hit. The block then updates that set's ranks on the clock edge.

The victim output names the way to replace on a miss. It is combinational from the ranks of the set currently presented on `acc_set`. The same ranks also appear on `look_ranks`, so the surrounding logic can see the whole recency order. A fully-associative cache uses the same block with one set and ASSOC equal to the number of blocks; no special-case logic is involved. ASSOC must be a power of two.

Top module: `lru_rank_tracker`

## Requirements
- R1: After reset, way w of every set holds rank w, so `victim_way` reads ASSOC-1 for every set. `look_ranks` carries way w's rank in bits [w*RANK_W +: RANK_W].
- R2: On a valid hit to way h, every other way with a rank below h's rank gains one, ways with a larger rank keep theirs, and way h becomes rank 0.
- R3: On a valid miss, the way whose rank is ASSOC-1 becomes rank 0 and every other way of the set gains one.
- R4: `victim_way` is, in the same cycle and without a clock edge, the way of the presented set whose rank equals ASSOC-1.
- R5: With `acc_valid` low, no rank of any set changes, whatever `acc_hit` and `acc_way` hold.
- R6: A valid hit on the way that already has rank 0 leaves every rank of the set unchanged.
- R7: The ranks of every set always form a permutation of 0..ASSOC-1.
- R8: An access changes only the ranks of the set it addresses.
- R9: In one 4-way set starting from reset, the block sequence A B C D D D B D E leaves ranks E=0, D=1, B=2, C=3, and C is the next victim. Misses fill the reported victim way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access to `acc_set` commits this cycle |
| acc_set | input | SET_W | Set index addressed (also selects the outputs) |
| acc_hit | input | 1 | 1 = hit on `acc_way`, 0 = miss |
| acc_way | input | RANK_W | Way that hit; ignored on a miss |
| victim_way | output | RANK_W | Least recently used way of `acc_set` |
| look_ranks | output | ASSOC*RANK_W | Current ranks of `acc_set`, way w at [w*RANK_W +: RANK_W] |

## Verification
`victim_way` and `look_ranks` follow `acc_set` in the same cycle. A rank update shows on the outputs once the clock edge that sampled `acc_valid` has passed. The bench drives every access on the falling edge and reads both outputs one nanosecond later, before the rising edge. At that point the outputs still reflect the state left by earlier accesses, and the bench compares them with its own model. It advances that model only after the rising edge, so every comparison lines up with the edge that commits the update.

// File: rtl/lru_pkg.sv
package lru_pkg;

    typedef enum logic {
        ACC_MISS = 1'b0,
        ACC_HIT  = 1'b1
    } acc_kind_e;

    // Rank of one way after an access: target becomes MRU,
    // more-recent neighbours age by one, older ones stay.
    function automatic int unsigned age_rank(
        input int unsigned cur,
        input int unsigned pivot,
        input bit          is_target
    );
        if (is_target)
            return 0;
        else if (cur < pivot)
            return cur + 1;
        else
            return cur;
    endfunction

endpackage

// File: rtl/lru_rank_store.sv
module lru_rank_store #(
    parameter int NUM_SETS = 16,
    parameter int ASSOC    = 4,
    parameter int RANK_W   = (ASSOC > 1) ? $clog2(ASSOC) : 1,
    parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [SET_W-1:0]        set_sel,
    input  logic [ASSOC*RANK_W-1:0] wr_ranks,
    output logic [ASSOC*RANK_W-1:0] rd_ranks
);

    logic [RANK_W-1:0] rank_mem [NUM_SETS][ASSOC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < ASSOC; w++) begin
                    rank_mem[s][w] <= RANK_W'(w);
                end
            end
        end else if (wr_en) begin
            for (int w = 0; w < ASSOC; w++) begin
                rank_mem[set_sel][w] <= wr_ranks[w*RANK_W +: RANK_W];
            end
        end
    end

    for (genvar gw = 0; gw < ASSOC; gw++) begin : g_rd
        assign rd_ranks[gw*RANK_W +: RANK_W] = rank_mem[set_sel][gw];
    end

endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
    parameter int ASSOC  = 4,
    parameter int RANK_W = (ASSOC > 1) ? $clog2(ASSOC) : 1
) (
    input  logic [ASSOC*RANK_W-1:0] ranks,
    output logic [RANK_W-1:0]       victim
);

    localparam logic [RANK_W-1:0] OLDEST = RANK_W'(ASSOC - 1);

    logic [ASSOC-1:0] is_oldest;

    for (genvar gw = 0; gw < ASSOC; gw++) begin : g_cmp
        assign is_oldest[gw] = (ranks[gw*RANK_W +: RANK_W] == OLDEST);
    end

    always_comb begin
        victim = '0;
        for (int w = 0; w < ASSOC; w++) begin
            if (is_oldest[w]) victim = RANK_W'(w);
        end
    end

endmodule

// File: rtl/lru_rank_next.sv
module lru_rank_next
    import lru_pkg::*;
#(
    parameter int ASSOC  = 4,
    parameter int RANK_W = (ASSOC > 1) ? $clog2(ASSOC) : 1
) (
    input  logic [ASSOC*RANK_W-1:0] cur_ranks,
    input  acc_kind_e               kind,
    input  logic [RANK_W-1:0]       hit_way,
    input  logic [RANK_W-1:0]       victim,
    output logic [ASSOC*RANK_W-1:0] nxt_ranks
);

    logic [RANK_W-1:0] target;
    logic [RANK_W-1:0] pivot;

    // A miss replaces the oldest way, whose rank is ASSOC-1, so the
    // same rule (age everything below the pivot) covers both cases.
    always_comb begin
        target = (kind == ACC_HIT) ? hit_way : victim;
        pivot  = cur_ranks[target*RANK_W +: RANK_W];
    end

    for (genvar gw = 0; gw < ASSOC; gw++) begin : g_age
        assign nxt_ranks[gw*RANK_W +: RANK_W] = RANK_W'(age_rank(
            int'(cur_ranks[gw*RANK_W +: RANK_W]),
            int'(pivot),
            (target == RANK_W'(gw))));
    end

endmodule

// File: rtl/lru_rank_tracker.sv
module lru_rank_tracker
    import lru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int ASSOC    = 4,
    localparam int RANK_W  = (ASSOC > 1) ? $clog2(ASSOC) : 1,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc_valid,
    input  logic [SET_W-1:0]        acc_set,
    input  logic                    acc_hit,
    input  logic [RANK_W-1:0]       acc_way,
    output logic [RANK_W-1:0]       victim_way,
    output logic [ASSOC*RANK_W-1:0] look_ranks
);

    logic [ASSOC*RANK_W-1:0] cur_ranks;
    logic [ASSOC*RANK_W-1:0] nxt_ranks;
    acc_kind_e               kind;

    assign kind = acc_hit ? ACC_HIT : ACC_MISS;

    lru_rank_store #(
        .NUM_SETS(NUM_SETS), .ASSOC(ASSOC), .RANK_W(RANK_W), .SET_W(SET_W)
    ) i_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (acc_valid),
        .set_sel (acc_set),
        .wr_ranks(nxt_ranks),
        .rd_ranks(cur_ranks)
    );

    lru_victim_pick #(
        .ASSOC(ASSOC), .RANK_W(RANK_W)
    ) i_pick (
        .ranks (cur_ranks),
        .victim(victim_way)
    );

    lru_rank_next #(
        .ASSOC(ASSOC), .RANK_W(RANK_W)
    ) i_next (
        .cur_ranks(cur_ranks),
        .kind     (kind),
        .hit_way  (acc_way),
        .victim   (victim_way),
        .nxt_ranks(nxt_ranks)
    );

    assign look_ranks = cur_ranks;

endmodule

// File: rtl/lru_rank_tracker_chk.sv
module lru_rank_tracker_chk #(
    parameter int NUM_SETS = 16,
    parameter int ASSOC    = 4,
    localparam int RANK_W  = (ASSOC > 1) ? $clog2(ASSOC) : 1,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    acc_valid,
    input logic [SET_W-1:0]        acc_set,
    input logic                    acc_hit,
    input logic [RANK_W-1:0]       acc_way,
    input logic [RANK_W-1:0]       victim_way,
    input logic [ASSOC*RANK_W-1:0] look_ranks
);

    function automatic logic [RANK_W-1:0] fld(
        input logic [ASSOC*RANK_W-1:0] v,
        input logic [RANK_W-1:0]       idx
    );
        return v[idx*RANK_W +: RANK_W];
    endfunction

    logic [ASSOC-1:0] seen;
    always_comb begin
        seen = '0;
        for (int w = 0; w < ASSOC; w++) begin
            seen[look_ranks[w*RANK_W +: RANK_W]] = 1'b1;
        end
    end

    a_r7_permutation: assert property (@(posedge clk) disable iff (rst)
        &seen);

    a_r4_victim_is_oldest: assert property (@(posedge clk) disable iff (rst)
        fld(look_ranks, victim_way) == RANK_W'(ASSOC - 1));

    a_r2_hit_becomes_mru: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_hit |=>
            (acc_set != $past(acc_set)) || (fld(look_ranks, $past(acc_way)) == '0));

    a_r3_victim_becomes_mru: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_hit |=>
            (acc_set != $past(acc_set)) || (fld(look_ranks, $past(victim_way)) == '0));

    a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (acc_set != $past(acc_set)) || $stable(look_ranks));

    a_r6_mru_hit_stable: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_hit && (fld(look_ranks, acc_way) == '0) |=>
            (acc_set != $past(acc_set)) || $stable(look_ranks));

endmodule

bind lru_rank_tracker lru_rank_tracker_chk #(
    .NUM_SETS(NUM_SETS), .ASSOC(ASSOC)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_set   (acc_set),
    .acc_hit   (acc_hit),
    .acc_way   (acc_way),
    .victim_way(victim_way),
    .look_ranks(look_ranks)
);

// File: tb/test_lru_rank_tracker.sv
module test_lru_rank_tracker;

    localparam int NUM_SETS = 16;
    localparam int ASSOC    = 4;
    localparam int RANK_W   = 2;
    localparam int SET_W    = 4;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    acc_valid = 1'b0;
    logic [SET_W-1:0]        acc_set = '0;
    logic                    acc_hit = 1'b0;
    logic [RANK_W-1:0]       acc_way = '0;
    logic [RANK_W-1:0]       victim_way;
    logic [ASSOC*RANK_W-1:0] look_ranks;

    int checks = 0;
    int errors = 0;
    int mdl [NUM_SETS][ASSOC];

    always #2 clk = ~clk;

    lru_rank_tracker #(.NUM_SETS(NUM_SETS), .ASSOC(ASSOC)) i_lru_rank_tracker (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_way(acc_way),
        .victim_way(victim_way), .look_ranks(look_ranks)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mdl_victim(input int s);
        for (int w = 0; w < ASSOC; w++) if (mdl[s][w] == ASSOC - 1) return w;
        return -1;
    endfunction

    function automatic int pack_ranks(input int s);
        int v = 0;
        for (int w = 0; w < ASSOC; w++) v |= mdl[s][w] << (w * RANK_W);
        return v;
    endfunction

    task automatic mdl_apply(input int s, input bit hit, input int way);
        int tgt = hit ? way : mdl_victim(s);
        int piv = mdl[s][tgt];
        for (int w = 0; w < ASSOC; w++) begin
            if (w == tgt) mdl[s][w] = 0;
            else if (mdl[s][w] < piv) mdl[s][w] = mdl[s][w] + 1;
        end
    endtask

    // Look at a set without committing anything and compare with the model.
    task automatic peek(input int s, input string req);
        @(negedge clk);
        acc_valid = 1'b0;
        acc_set   = SET_W'(s);
        #1;
        chk({req, " ranks"}, int'(look_ranks), pack_ranks(s));
        chk({req, " victim"}, int'(victim_way), mdl_victim(s));
    endtask

    // Present an access, check pre-state outputs, commit on the edge.
    task automatic access(input int s, input bit hit, input int way, input string req);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_set   = SET_W'(s);
        acc_hit   = hit;
        acc_way   = RANK_W'(way);
        #1;
        chk({req, " R4 victim"}, int'(victim_way), mdl_victim(s));
        chk({req, " ranks"}, int'(look_ranks), pack_ranks(s));
        @(posedge clk);
        mdl_apply(s, hit, way);
        #0.5;
        acc_valid = 1'b0;
    endtask

    function automatic bit is_perm(input logic [ASSOC*RANK_W-1:0] v);
        logic [ASSOC-1:0] m = '0;
        for (int w = 0; w < ASSOC; w++) m[v[w*RANK_W +: RANK_W]] = 1'b1;
        return &m;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int s = 0; s < NUM_SETS; s++)
            for (int w = 0; w < ASSOC; w++) mdl[s][w] = w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset ordering in every set
        for (int s = 0; s < NUM_SETS; s++) begin
            @(negedge clk);
            acc_set = SET_W'(s);
            #1;
            chk("R1 ranks", int'(look_ranks), 32'he4);
            chk("R1 victim", int'(victim_way), ASSOC - 1);
        end

        // R9: A B C D D D B D E on set 7 (A->w3, B->w2, C->w1, D->w0)
        access(7, 0, 0, "R9 A");
        access(7, 0, 0, "R9 B");
        access(7, 0, 0, "R9 C");
        access(7, 0, 0, "R9 D");
        access(7, 1, 0, "R6 D");
        peek(7, "R6 after MRU hit");
        access(7, 1, 0, "R6 D");
        access(7, 1, 2, "R2 B");
        access(7, 1, 0, "R2 D");
        access(7, 0, 0, "R3 E");
        @(negedge clk);
        acc_set = 4'd7;
        #1;
        // way0 D=1, way1 C=3, way2 B=2, way3 E=0 -> 8'b00_10_11_01
        chk("R9 final ranks", int'(look_ranks), 32'h2d);
        chk("R9 next victim C", int'(victim_way), 1);

        // R5: idle cycles with hit info present change nothing
        @(negedge clk);
        acc_valid = 1'b0;
        acc_set   = 4'd7;
        acc_hit   = 1'b1;
        acc_way   = 2'd1;
        repeat (3) @(posedge clk);
        #1;
        chk("R5 idle ranks", int'(look_ranks), 32'h2d);

        // R8: other sets untouched by set 7 traffic
        peek(3, "R8 set3");
        peek(8, "R8 set8");

        // R3: miss on a fresh set
        access(2, 0, 1, "R3 miss");
        peek(2, "R3 after miss");

        // Random mix; model compared at every access
        for (int n = 0; n < 3000; n++) begin
            int s   = int'($urandom_range(NUM_SETS - 1));
            bit hit = ($urandom_range(9) < 6);
            int way = int'($urandom_range(ASSOC - 1));
            access(s, hit, way, hit ? "R2 rand" : "R3 rand");
            chk("R7 permutation", int'(is_perm(look_ranks)), 1);
        end

        for (int s = 0; s < NUM_SETS; s++) peek(s, "R8 sweep");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule